// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Interrupt Bank

This block drives a small number of PWM outputs (four by default, up to 32) from a word-addressed register port. Each channel holds a mode word, a duty value, a period value and a 20-bit counter that software can read. A channel advances its counter on a clock-enable tick. The tick comes from the core clock or from one of two external tick inputs, and the channel's mode register picks which one. In edge mode the counter runs from zero up to period minus one and then wraps. In centre mode it runs up to the period value and back down to zero, so one cycle takes twice as long. In both modes the output is high while the counter is below the duty value.

Channels are started and stopped through a pair of write-one registers: a 1 written to the start register starts that channel, and a 1 written to the stop register stops it. A read-only status word shows which channels are running. The interrupt mask works the same way, with a set register and a clear register, and it can be read back. Each running channel latches a pending flag when its period ends. Reading the pending register returns the flags and clears them in the same access. The single interrupt line is high while any pending flag has its mask bit set.

The register port is a plain one-cycle access with no back-pressure. A write takes effect at the clock edge where `bus_wr` is sampled. Read data appears on `bus_rdata` from the edge where `bus_rd` is sampled and holds until the next read. Bits [1:0] of the address are ignored.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every register reads zero, `pwm_out` is all zero and `irq` is low.
- R2: Writing word offset 0x04 starts each channel whose bit is 1. Writing 0x08 stops each channel whose bit is 1. Zero bits leave their channel unchanged. Offset 0x0C returns bit n set while channel n runs.
- R3: Writing 1s to offset 0x10 sets the matching mask bits, writing 1s to 0x14 clears them, and offset 0x18 returns the mask. Mask bits change no other way.
- R4: Channel n's window starts at 0x200 + n*0x20: mode at +0x00, duty at +0x04, period at +0x08, counter at +0x0C. In edge mode (mode bit 8 = 0), each tick advances the counter. When a tick arrives with counter+1 >= period, the counter returns to 0. The output is high while the channel runs and counter < duty.
- R5: In centre mode (mode bit 8 = 1), ticks take the counter from 0 up to the period value and then back down to 0. A period end happens on the tick that reaches 0 while counting down, which makes the cycle 2*period ticks long.
- R6: Mode bits [3:0] pick the tick source: 0 advances on every clock, 11 on `tick_a`, 12 on `tick_b`. Any other value never advances the counter.
- R7: A running channel sets its pending bit at each period end. Reading offset 0x1C returns the pending bits and clears them. A period end in the same cycle as that read stays pending.
- R8: `irq` is high exactly while some pending bit also has its mask bit set. It follows the registers without extra delay.
- R9: Stopping a channel forces its output low and its counter to 0 within one cycle. Its mode, duty and period values are kept.
- R10: `bus_rdata` is loaded at the edge where `bus_rd` is sampled and held otherwise. Unmapped addresses read zero. This covers offset 0x00, the write-only offsets, and the windows of channels at or beyond the channel count.
- R11: The counter register is read-only: a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W (12) | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tick_a | input | 1 | External tick source A |
| tick_b | input | 1 | External tick source B |
| pwm_out | output | N_CH (4) | One PWM output per channel |
| irq | output | 1 | Masked interrupt request |

## Verification
The bound checker watches the set/clear registers on every cycle. A start or stop write must leave its 1 bits set or cleared, and with no such write the enable and mask words must hold. It also checks that a pending read leaves only the period ends of that same cycle, that no stopped channel drives its output or raises an event, and that the interrupt line never rises without both a pending and a mask bit. The bench's scenarios are needed for the rest: counter sequences and output shape in edge and centre mode, tick-source selection, the doubled period in centre mode, the read racing a period end, and the ignored writes and reads to unmapped offsets.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  // global word offsets
  localparam int OFS_GMODE = 'h00;
  localparam int OFS_START = 'h04;
  localparam int OFS_STOP  = 'h08;
  localparam int OFS_RUN   = 'h0C;
  localparam int OFS_MSET  = 'h10;
  localparam int OFS_MCLR  = 'h14;
  localparam int OFS_MASK  = 'h18;
  localparam int OFS_PEND  = 'h1C;
  // channel windows
  localparam int CH_BASE   = 'h200;
  localparam int CH_STRIDE = 'h20;
  // register index inside a window (address bits [4:2])
  typedef enum logic [2:0] {
    WIN_MODE = 3'd0,
    WIN_DUTY = 3'd1,
    WIN_PRD  = 3'd2,
    WIN_CNT  = 3'd3
  } win_reg_e;
  // tick source codes in mode bits [3:0]
  localparam logic [3:0] SRC_CORE = 4'd0;
  localparam logic [3:0] SRC_EXTA = 4'd11;
  localparam logic [3:0] SRC_EXTB = 4'd12;
  localparam int CENTER_BIT = 8;
endpackage

// File: rtl/pwm_bank_setclr.sv
module pwm_bank_setclr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (q_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/pwm_bank_pend.sv
module pwm_bank_pend #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         ack_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  // a read clears old flags; same-cycle events survive the clear
  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (ack_i ? '0 : pend_o) | evt_i;
  end
  assign irq_o = |(pend_o & mask_i);
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_a,
  input  logic             tick_b,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CNT_W-1:0] cfg_data,
  output logic [3:0]       src_o,
  output logic             center_o,
  output logic [CNT_W-1:0] duty_o,
  output logic [CNT_W-1:0] prd_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o,
  output logic             evt_o
);
  logic             tick, adv, up_q, at_top, at_bot;
  logic [CNT_W:0]   cnt_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_o    <= '0;
      center_o <= 1'b0;
      duty_o   <= '0;
      prd_o    <= '0;
    end else if (cfg_we) begin
      unique case (cfg_sel)
        2'd0: begin
          src_o    <= cfg_data[3:0];
          center_o <= cfg_data[CENTER_BIT];
        end
        2'd1:    duty_o <= cfg_data;
        2'd2:    prd_o  <= cfg_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (src_o)
      SRC_CORE: tick = 1'b1;
      SRC_EXTA: tick = tick_a;
      SRC_EXTB: tick = tick_b;
      default:  tick = 1'b0;
    endcase
  end

  assign adv     = en_i & tick;
  assign cnt_inc = {1'b0, cnt_o} + 1'b1;
  assign at_top  = cnt_inc >= {1'b0, prd_o};
  assign at_bot  = cnt_o <= CNT_W'(1);
  assign evt_o   = adv & (center_o ? (!up_q & at_bot) : at_top);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      cnt_o <= '0;
      up_q  <= 1'b1;
    end else if (adv) begin
      if (!center_o) begin
        cnt_o <= at_top ? '0 : cnt_inc[CNT_W-1:0];
        up_q  <= 1'b1;
      end else if (up_q) begin
        if (at_top) begin
          cnt_o <= prd_o;
          up_q  <= 1'b0;
        end else begin
          cnt_o <= cnt_inc[CNT_W-1:0];
        end
      end else if (at_bot) begin
        cnt_o <= '0;
        up_q  <= 1'b1;
      end else begin
        cnt_o <= cnt_o - 1'b1;
      end
    end
  end

  assign pwm_o = en_i & (cnt_o < duty_o);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 20,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_a,
  input  logic              tick_b,
  output logic [N_CH-1:0]   pwm_out,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 5;

  logic [ADDR_W-1:0] win_off;
  logic [IDX_W-1:0]  ch_idx;
  logic              glob_hit, ch_hit;
  logic [2:0]        rsel;
  logic [N_CH-1:0]   en_set, en_clr, m_set, m_clr;
  logic [N_CH-1:0]   en_q, mask_q, pend_q, evt;
  logic              ack;
  logic [31:0]       rd_val;

  logic [N_CH-1:0][3:0]       src_a;
  logic [N_CH-1:0]            center_a;
  logic [N_CH-1:0][CNT_W-1:0] duty_a, prd_a, cnt_a;

  // address decode
  assign win_off  = bus_addr - ADDR_W'(CH_BASE);
  assign ch_idx   = win_off[ADDR_W-1:5];
  assign glob_hit = (bus_addr[ADDR_W-1:5] == '0);
  assign ch_hit   = (bus_addr >= ADDR_W'(CH_BASE)) && (ch_idx < IDX_W'(N_CH));
  assign rsel     = bus_addr[4:2];

  always_comb begin
    en_set = '0;
    en_clr = '0;
    m_set  = '0;
    m_clr  = '0;
    if (bus_wr && glob_hit) begin
      unique case (rsel)
        3'(OFS_START >> 2): en_set = bus_wdata[N_CH-1:0];
        3'(OFS_STOP  >> 2): en_clr = bus_wdata[N_CH-1:0];
        3'(OFS_MSET  >> 2): m_set  = bus_wdata[N_CH-1:0];
        3'(OFS_MCLR  >> 2): m_clr  = bus_wdata[N_CH-1:0];
        default: ;
      endcase
    end
  end
  assign ack = bus_rd && glob_hit && (rsel == 3'(OFS_PEND >> 2));

  pwm_bank_setclr #(.W(N_CH)) u_run (
    .clk(clk), .rst_n(rst_n), .set_i(en_set), .clr_i(en_clr), .q_o(en_q)
  );
  pwm_bank_setclr #(.W(N_CH)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_i(m_set), .clr_i(m_clr), .q_o(mask_q)
  );
  pwm_bank_pend #(.W(N_CH)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .ack_i(ack),
    .mask_i(mask_q), .pend_o(pend_q), .irq_o(irq)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic cfg_we;
    assign cfg_we = bus_wr && ch_hit && (ch_idx == IDX_W'(i)) &&
                    (rsel < 3'(WIN_CNT));
    pwm_bank_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .en_i(en_q[i]),
      .tick_a(tick_a), .tick_b(tick_b),
      .cfg_we(cfg_we), .cfg_sel(rsel[1:0]), .cfg_data(bus_wdata[CNT_W-1:0]),
      .src_o(src_a[i]), .center_o(center_a[i]), .duty_o(duty_a[i]),
      .prd_o(prd_a[i]), .cnt_o(cnt_a[i]), .pwm_o(pwm_out[i]), .evt_o(evt[i])
    );
  end

  // read mux
  always_comb begin
    rd_val = '0;
    if (glob_hit) begin
      unique case (rsel)
        3'(OFS_RUN  >> 2): rd_val = 32'(en_q);
        3'(OFS_MASK >> 2): rd_val = 32'(mask_q);
        3'(OFS_PEND >> 2): rd_val = 32'(pend_q);
        default: ;
      endcase
    end
    for (int i = 0; i < N_CH; i++) begin
      if (ch_hit && ch_idx == IDX_W'(i)) begin
        unique case (rsel)
          3'(WIN_MODE): rd_val = 32'({center_a[i], 4'b0000, src_a[i]});
          3'(WIN_DUTY): rd_val = 32'(duty_a[i]);
          3'(WIN_PRD):  rd_val = 32'(prd_a[i]);
          3'(WIN_CNT):  rd_val = 32'(cnt_a[i]);
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [N_CH-1:0]   en_q,
  input logic [N_CH-1:0]   mask_q,
  input logic [N_CH-1:0]   pend_q,
  input logic [N_CH-1:0]   evt,
  input logic [N_CH-1:0]   pwm_out,
  input logic              irq
);
  logic [ADDR_W-1:0] wa;
  logic [N_CH-1:0]   wd;
  logic              w_start, w_stop, w_mset, w_mclr, r_pend;
  assign wa      = {bus_addr[ADDR_W-1:2], 2'b00};
  assign wd      = bus_wdata[N_CH-1:0];
  assign w_start = bus_wr && wa == ADDR_W'(OFS_START);
  assign w_stop  = bus_wr && wa == ADDR_W'(OFS_STOP);
  assign w_mset  = bus_wr && wa == ADDR_W'(OFS_MSET);
  assign w_mclr  = bus_wr && wa == ADDR_W'(OFS_MCLR);
  assign r_pend  = bus_rd && wa == ADDR_W'(OFS_PEND);

  a_r2_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    w_start |=> ((en_q & $past(wd)) == $past(wd)));
  a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    w_stop |=> ((en_q & $past(wd)) == '0));
  a_r2_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_start || w_stop) |=> $stable(en_q));
  a_r3_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_mset || w_mclr) |=> $stable(mask_q));
  a_r3_mset_sets: assert property (@(posedge clk) disable iff (!rst_n)
    w_mset |=> ((mask_q & $past(wd)) == $past(wd)));
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    r_pend |=> (pend_q == $past(evt)));
  a_r7_evt_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~en_q) == '0);
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0 && pend_q != '0));
  a_r9_out_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & ~en_q) == '0);
endmodule

bind pwm_bank pwm_bank_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .en_q(en_q),
  .mask_q(mask_q), .pend_q(pend_q), .evt(evt), .pwm_out(pwm_out), .irq(irq)
);

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_a = 1'b0, tick_b = 1'b0;
  logic [3:0]  pwm_out;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  logic [31:0] msk_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  pwm_bank u_pwm_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_a(tick_a), .tick_b(tick_b), .pwm_out(pwm_out), .irq(irq)
  );

  function automatic logic [11:0] cha(int n, int r);
    return 12'(32'h200 + n * 32 + r);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks start and end on a falling edge
  task automatic bwrite(logic [11:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic bread(logic [11:0] a, logic [31:0] exp, logic [31:0] msk, string tag);
    exp_q.push_back(exp); msk_q.push_back(msk); tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_a();
    tick_a = 1'b1; @(negedge clk); tick_a = 1'b0;
  endtask

  task automatic pulse_b();
    tick_b = 1'b1; @(negedge clk); tick_b = 1'b0;
  endtask

  // scoreboard monitor
  always begin
    @(posedge clk);
    if (bus_rd) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e, m;
        string t;
        e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
        check(t, bus_rdata & m, e & m);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pwm_out", 32'(pwm_out), 0);
    check("R1 irq", 32'(irq), 0);
    bread(12'h00C, 0, '1, "R1 run status");
    bread(12'h018, 0, '1, "R1 mask");
    bread(12'h01C, 0, '1, "R1 pending");
    bread(cha(0, 4), 0, '1, "R1 duty");
    bread(cha(0, 12), 0, '1, "R1 counter");

    // ch0: edge mode on tick_a, duty 2, period 4
    bwrite(cha(0, 0), 32'd11);
    bwrite(cha(0, 4), 32'd2);
    bwrite(cha(0, 8), 32'd4);
    bread(cha(0, 0), 32'd11, '1, "R4 mode readback");
    bwrite(12'h004, 32'h1);
    bread(12'h00C, 32'h1, '1, "R2 start ch0");
    check("R4 out at count 0", 32'(pwm_out[0]), 1);
    pulse_a(); check("R4 out at count 1", 32'(pwm_out[0]), 1);
    pulse_a(); check("R4 out at count 2", 32'(pwm_out[0]), 0);
    pulse_a();
    bread(cha(0, 12), 32'd3, '1, "R4 counter 3");
    bread(12'h01C, 0, '1, "R7 no period end yet");
    pulse_a();
    check("R4 out after wrap", 32'(pwm_out[0]), 1);
    check("R8 irq masked off", 32'(irq), 0);
    bread(cha(0, 12), 0, '1, "R4 counter wrapped");
    bread(12'h01C, 32'h1, '1, "R7 pending after period");
    bread(12'h01C, 0, '1, "R7 cleared by read");

    // R3 / R8 mask
    bwrite(12'h010, 32'h1);
    bread(12'h018, 32'h1, '1, "R3 mask set");
    repeat (4) pulse_a();
    check("R8 irq raised", 32'(irq), 1);
    bwrite(12'h014, 32'h1);
    check("R8 irq drops with mask clear", 32'(irq), 0);
    bread(12'h018, 0, '1, "R3 mask cleared");
    bwrite(12'h010, 32'h1);
    check("R8 irq back with mask", 32'(irq), 1);
    bread(12'h01C, 32'h1, '1, "R7 pending read");
    check("R8 irq after ack", 32'(irq), 0);

    // R7 race: period end in the read cycle
    repeat (3) pulse_a();
    exp_q.push_back(0); msk_q.push_back('1); tag_q.push_back("R7 race old value");
    bus_rd = 1'b1; bus_addr = 12'h01C; tick_a = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; tick_a = 1'b0;
    bread(12'h01C, 32'h1, '1, "R7 race event kept");

    // R2 zero bits, R6 sources
    bwrite(cha(1, 0), 32'd12);
    bwrite(cha(1, 4), 32'd1);
    bwrite(cha(1, 8), 32'd3);
    bwrite(12'h004, 32'h2);
    bread(12'h00C, 32'h3, '1, "R2 zero bits keep ch0");
    bwrite(12'h008, 32'h0);
    bread(12'h00C, 32'h3, '1, "R2 zero stop write");
    pulse_a();
    bread(cha(1, 12), 0, '1, "R6 tick_a ignored by ch1");
    bread(cha(0, 12), 32'd1, '1, "R6 tick_a moves ch0");
    pulse_b();
    bread(cha(1, 12), 32'd1, '1, "R6 tick_b moves ch1");
    check("R4 ch1 out at count=duty", 32'(pwm_out[1]), 0);
    bwrite(cha(2, 0), 32'd5);
    bwrite(cha(2, 8), 32'd9);
    bwrite(12'h004, 32'h4);
    pulse_a(); pulse_b();
    bread(cha(2, 12), 0, '1, "R6 unused source holds");
    bwrite(cha(3, 8), 32'd1000);
    bwrite(12'h004, 32'h8);
    bread(cha(3, 12), 32'd1, '1, "R6 core clock count 1");
    bread(cha(3, 12), 32'd2, '1, "R6 core clock count 2");
    bwrite(12'h008, 32'h8);
    bread(cha(3, 12), 0, '1, "R9 stop clears counter");

    // R9 on ch0 (count 2)
    bwrite(cha(0, 4), 32'd4);
    pulse_a();
    check("R9 out high before stop", 32'(pwm_out[0]), 1);
    bwrite(12'h008, 32'h1);
    check("R9 out low after stop", 32'(pwm_out[0]), 0);
    bread(cha(0, 12), 0, '1, "R9 ch0 counter zero");
    bread(cha(0, 4), 32'd4, '1, "R9 duty kept");
    bread(12'h00C, 32'h6, '1, "R2 run after stops");

    // R5 centre mode on ch1
    bwrite(12'h008, 32'h2);
    bread(12'h01C, 0, 0, "R7 flush");
    bwrite(cha(1, 0), 32'h10C);
    bwrite(cha(1, 4), 32'd2);
    bwrite(cha(1, 8), 32'd3);
    bwrite(12'h004, 32'h2);
    check("R5 out at 0", 32'(pwm_out[1]), 1);
    pulse_b(); check("R5 out at 1", 32'(pwm_out[1]), 1);
    pulse_b(); check("R5 out at 2", 32'(pwm_out[1]), 0);
    pulse_b();
    bread(cha(1, 12), 32'd3, '1, "R5 top reached");
    pulse_b(); check("R5 out at 2 down", 32'(pwm_out[1]), 0);
    pulse_b(); check("R5 out at 1 down", 32'(pwm_out[1]), 1);
    bread(12'h01C, 0, '1, "R5 no end before bottom");
    pulse_b();
    check("R8 unmasked ch1 no irq", 32'(irq), 0);
    bread(cha(1, 12), 0, '1, "R5 back to zero");
    bread(12'h01C, 32'h2, '1, "R5 end after 2*period");

    // R10 / R11
    bwrite(12'h000, 32'hFFFF);
    bread(12'h000, 0, '1, "R10 offset 0 reads zero");
    bread(12'h004, 0, '1, "R10 write-only reads zero");
    bread(cha(5, 4), 0, '1, "R10 beyond channel count");
    pulse_b();
    bwrite(cha(1, 12), 32'h55);
    bread(cha(1, 12), 32'd1, '1, "R11 counter write ignored");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R10 reads outstanding", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule